// File: doc/BRIEF.md
# PWM Sequence Value Decoder

This block walks a table of 16-bit duty values held in memory and turns it into the compare values of a four-channel pulse generator. After a start pulse it reads halfwords one at a time over a request/response port. It gathers the halfwords that make up one step into a staging buffer, then copies them to the channel compare outputs at the next period boundary. The copy follows the load mode. One halfword can feed every channel, two halfwords can feed channel pairs, or four halfwords can feed the channels one each. In the waveform mode the fourth halfword becomes the counter top value instead of a channel value.

The pacing follows the step mode. In automatic mode each step stays on the outputs for its first period plus a number of extra periods set by the refresh input. In triggered mode the block moves to the next step only after an explicit step pulse, and the refresh input has no effect. The next step is fetched as soon as the current one is applied. When the last staged step has run out, a done pulse marks the end of the sequence.

Top module: `pwm_seq_decoder`

## Requirements
- R1: After reset all four compare values are 0, the top value is 16'h03FF, and busy, done, last-read and the read request are all low.
- R2: The halfwords are requested at byte addresses base + 2*i for i = 0, 1, ... up to the count minus one, one request per halfword. Only one request is outstanding at a time. A pending request keeps its address until it is accepted.
- R3: In load mode 0, the single halfword of a step goes to all four channels.
- R4: In load mode 1, the first halfword of a step goes to channels 0 and 1 and the second goes to channels 2 and 3.
- R5: In load mode 2, the four halfwords of a step go to channels 0, 1, 2 and 3 in ascending address order.
- R6: In load mode 3, the first three halfwords go to channels 0 to 2 and the fourth replaces the top value. Channel 3 keeps its value. The top value changes in no other mode.
- R7: The compare and top outputs change only on the clock edge that samples a period-end pulse.
- R8: In automatic mode the first step is applied at the first period end after it is staged. Each step then stays for refresh+1 periods.
- R9: In triggered mode, after the first step, a period end without a preceding step pulse leaves the outputs unchanged. After a step pulse, the next period end applies the next step whatever the refresh input holds.
- R10: Last-read pulses for one cycle, once per sequence, in the cycle after the response carrying the final halfword is accepted.
- R11: The sequence ends at the period end where the last step's time expires. In automatic mode that is after its refresh+1 periods; in triggered mode it is at the first period end after a step pulse with no step left. At that edge busy falls, done pulses for one cycle, and the outputs keep their last values.
- R12: The configuration word holds the load mode in bits [1:0] (0 common, 1 paired, 2 per-channel, 3 waveform) and the step mode in bit 2 (0 automatic, 1 triggered). The count is given in halfwords and is a multiple of the halfwords per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a sequence; latches base, count, configuration and refresh |
| base_addr_i | input | 32 | Byte address of the first halfword |
| len_i | input | 16 | Number of halfwords in the sequence |
| cfg_i | input | 3 | Configuration word: load mode [1:0], step mode [2] |
| refresh_i | input | 8 | Extra periods per step in automatic mode |
| period_end_i | input | 1 | One-cycle pulse at each generator period boundary |
| next_step_i | input | 1 | One-cycle step request in triggered mode |
| req_valid_o | output | 1 | Read request valid |
| req_addr_o | output | 32 | Read request byte address |
| req_ready_i | input | 1 | Read request accepted |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_data_i | input | 16 | Read response halfword |
| cmp_o | output | 64 | Channel compare values, channel c in bits [16c+15:16c] |
| top_o | output | 16 | Counter top value |
| last_read_o | output | 1 | Final halfword of the sequence has been read |
| done_o | output | 1 | Sequence finished |
| busy_o | output | 1 | Sequence in progress |

## Verification
The properties assume the following about the inputs. The memory side answers each accepted request with exactly one response and sends no response while nothing is outstanding. The count is a whole number of steps. Periods are long enough for a full step to be fetched between two boundaries. The stimulus keeps within this: the responder holds ready low for at most one cycle in a row and adds a delay of at most two cycles. Period pulses are spaced 32 cycles apart, and the random count is always built as a step count times the halfwords per step.

// File: rtl/pwmdec_pkg.sv
package pwmdec_pkg;

   localparam int NCH = 4;

   typedef enum logic [1:0] {
      LD_COMMON = 2'd0,
      LD_PAIRED = 2'd1,
      LD_SPLIT  = 2'd2,
      LD_WAVE   = 2'd3
   } ld_mode_e;

   // halfwords that make up one step for a load mode
   function automatic logic [2:0] hw_per_step(ld_mode_e m);
      case (m)
         LD_COMMON: hw_per_step = 3'd1;
         LD_PAIRED: hw_per_step = 3'd2;
         default:   hw_per_step = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/pwmdec_fetch.sv
module pwmdec_fetch
   import pwmdec_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int HW_W   = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  active,
   input  logic                  take,
   input  logic [ADDR_W-1:0]     base,
   input  logic [LEN_W-1:0]      len,
   input  ld_mode_e              mode,
   output logic                  req_valid,
   output logic [ADDR_W-1:0]     req_addr,
   input  logic                  req_ready,
   input  logic                  rsp_valid,
   input  logic [HW_W-1:0]       rsp_data,
   output logic [NCH*HW_W-1:0]   stage,
   output logic                  stage_full,
   output logic                  exhausted,
   output logic                  last_read
);
   localparam int SLOT_W = $clog2(NCH);

   logic [LEN_W-1:0]  idx;
   logic [SLOT_W-1:0] slot;
   logic              outstanding;
   logic              rsp_ok;
   logic              final_hw;
   logic              step_fill;
   logic [2:0]        per_step;

   assign per_step  = hw_per_step(mode);
   assign rsp_ok    = rsp_valid & outstanding;
   assign final_hw  = ({1'b0, idx} + 1'b1) == {1'b0, len};
   assign step_fill = ({1'b0, slot} + 3'd1) == per_step;
   assign exhausted = (idx == len);
   assign req_valid = active & ~stage_full & ~outstanding & ~exhausted;
   assign req_addr  = base + ADDR_W'({idx, 1'b0});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx         <= '0;
         slot        <= '0;
         outstanding <= 1'b0;
         stage_full  <= 1'b0;
         last_read   <= 1'b0;
      end else if (start) begin
         idx         <= '0;
         slot        <= '0;
         outstanding <= 1'b0;
         stage_full  <= 1'b0;
         last_read   <= 1'b0;
      end else begin
         last_read <= rsp_ok & final_hw;
         if (req_valid && req_ready) outstanding <= 1'b1;
         if (rsp_ok) begin
            outstanding <= 1'b0;
            idx         <= idx + 1'b1;
            if (step_fill || final_hw) begin
               stage_full <= 1'b1;
               slot       <= '0;
            end else begin
               slot <= slot + 1'b1;
            end
         end else if (take) begin
            stage_full <= 1'b0;
         end
      end
   end

   for (genvar s = 0; s < NCH; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage[s*HW_W +: HW_W] <= '0;
         else if (!start && rsp_ok && slot == SLOT_W'(s))
            stage[s*HW_W +: HW_W] <= rsp_data;
      end
   end

endmodule

// File: rtl/pwmdec_pace.sv
module pwmdec_pace #(
   parameter int REP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             active,
   input  logic             trig,
   input  logic             period_end,
   input  logic             next_step,
   input  logic [REP_W-1:0] refresh,
   input  logic             stage_full,
   input  logic             exhausted,
   output logic             take,
   output logic             finish
);
   logic             playing;
   logic             adv_req;
   logic [REP_W-1:0] rep;
   logic             due;
   logic             boundary;

   assign boundary = active & period_end;
   assign due      = ~playing | (trig ? adv_req : (rep == '0));
   assign take     = boundary & due & stage_full;
   assign finish   = boundary & due & ~stage_full & exhausted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         playing <= 1'b0;
         adv_req <= 1'b0;
         rep     <= '0;
      end else if (start) begin
         playing <= 1'b0;
         adv_req <= 1'b0;
         rep     <= '0;
      end else if (take) begin
         playing <= 1'b1;
         adv_req <= 1'b0;
         rep     <= refresh;
      end else if (finish) begin
         playing <= 1'b0;
         adv_req <= 1'b0;
      end else begin
         if (boundary && !due && !trig) rep <= rep - 1'b1;
         if (active && trig && playing && next_step) adv_req <= 1'b1;
      end
   end

endmodule

// File: rtl/pwmdec_apply.sv
module pwmdec_apply
   import pwmdec_pkg::*;
#(
   parameter int HW_W     = 16,
   parameter int TOP_INIT = 16'h03FF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  ld_mode_e            mode,
   input  logic [NCH*HW_W-1:0] stage,
   output logic [NCH*HW_W-1:0] cmp,
   output logic [HW_W-1:0]     top
);
   logic [HW_W-1:0] slot_v [NCH];

   for (genvar s = 0; s < NCH; s++) begin : g_unpack
      assign slot_v[s] = stage[s*HW_W +: HW_W];
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [HW_W-1:0] q;
      logic [HW_W-1:0] d;

      always_comb begin
         d = q;
         case (mode)
            LD_COMMON: d = slot_v[0];
            LD_PAIRED: d = slot_v[c/2];
            LD_SPLIT:  d = slot_v[c];
            default: begin
               if (c != NCH-1) d = slot_v[c];
            end
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q <= '0;
         else if (take) q <= d;
      end

      assign cmp[c*HW_W +: HW_W] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      top <= HW_W'(TOP_INIT);
      else if (take && mode == LD_WAVE) top <= slot_v[NCH-1];
   end

endmodule

// File: rtl/pwm_seq_decoder.sv
module pwm_seq_decoder
   import pwmdec_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int LEN_W    = 16,
   parameter int HW_W     = 16,
   parameter int REP_W    = 8,
   parameter int TOP_INIT = 16'h03FF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [ADDR_W-1:0]   base_addr_i,
   input  logic [LEN_W-1:0]    len_i,
   input  logic [2:0]          cfg_i,
   input  logic [REP_W-1:0]    refresh_i,
   input  logic                period_end_i,
   input  logic                next_step_i,
   output logic                req_valid_o,
   output logic [ADDR_W-1:0]   req_addr_o,
   input  logic                req_ready_i,
   input  logic                rsp_valid_i,
   input  logic [HW_W-1:0]     rsp_data_i,
   output logic [4*HW_W-1:0]   cmp_o,
   output logic [HW_W-1:0]     top_o,
   output logic                last_read_o,
   output logic                done_o,
   output logic                busy_o
);
   if (HW_W < 2) begin : g_bad_hw
      $error("HW_W must be at least 2");
   end
   if (LEN_W < 3) begin : g_bad_len
      $error("LEN_W must be at least 3");
   end
   if (ADDR_W <= LEN_W) begin : g_bad_addr
      $error("ADDR_W must exceed LEN_W");
   end

   logic [ADDR_W-1:0] base_q;
   logic [LEN_W-1:0]  len_q;
   ld_mode_e          mode_q;
   logic              trig_q;
   logic [REP_W-1:0]  refresh_q;
   logic              active;
   logic              done_q;
   logic              take;
   logic              finish;
   logic              stage_full;
   logic              exhausted;
   logic [NCH*HW_W-1:0] stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q    <= '0;
         len_q     <= '0;
         mode_q    <= LD_COMMON;
         trig_q    <= 1'b0;
         refresh_q <= '0;
         active    <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= finish & ~start_i;
         if (start_i) begin
            base_q    <= base_addr_i;
            len_q     <= len_i;
            mode_q    <= ld_mode_e'(cfg_i[1:0]);
            trig_q    <= cfg_i[2];
            refresh_q <= refresh_i;
            active    <= 1'b1;
         end else if (finish) begin
            active <= 1'b0;
         end
      end
   end

   pwmdec_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .HW_W(HW_W)) i_fetch (
      .clk(clk), .rst_n(rst_n), .start(start_i), .active(active), .take(take),
      .base(base_q), .len(len_q), .mode(mode_q),
      .req_valid(req_valid_o), .req_addr(req_addr_o), .req_ready(req_ready_i),
      .rsp_valid(rsp_valid_i), .rsp_data(rsp_data_i),
      .stage(stage), .stage_full(stage_full), .exhausted(exhausted),
      .last_read(last_read_o)
   );

   pwmdec_pace #(.REP_W(REP_W)) i_pace (
      .clk(clk), .rst_n(rst_n), .start(start_i), .active(active), .trig(trig_q),
      .period_end(period_end_i), .next_step(next_step_i), .refresh(refresh_q),
      .stage_full(stage_full), .exhausted(exhausted),
      .take(take), .finish(finish)
   );

   pwmdec_apply #(.HW_W(HW_W), .TOP_INIT(TOP_INIT)) i_apply (
      .clk(clk), .rst_n(rst_n), .take(take), .mode(mode_q), .stage(stage),
      .cmp(cmp_o), .top(top_o)
   );

   assign done_o = done_q;
   assign busy_o = active;

endmodule

// File: rtl/pwm_seq_decoder_chk.sv
module pwm_seq_decoder_chk #(
   parameter int ADDR_W = 32,
   parameter int HW_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              period_end_i,
   input logic              req_valid_o,
   input logic              req_ready_i,
   input logic [ADDR_W-1:0] req_addr_o,
   input logic [4*HW_W-1:0] cmp_o,
   input logic [HW_W-1:0]   top_o,
   input logic [1:0]        mode_q,
   input logic              done_o,
   input logic              busy_o
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o && !req_ready_i && !start_i |=> req_valid_o && $stable(req_addr_o)); // R2

   AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> !req_addr_o[0]); // R2

   AST_OUT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !period_end_i |=> $stable(cmp_o) && $stable(top_o)); // R7

   AST_TOP_WAVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != 2'd3 |=> $stable(top_o)); // R6

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R11

endmodule

bind pwm_seq_decoder pwm_seq_decoder_chk #(.ADDR_W(ADDR_W), .HW_W(HW_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .period_end_i(period_end_i),
   .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
   .cmp_o(cmp_o), .top_o(top_o), .mode_q(mode_q), .done_o(done_o), .busy_o(busy_o)
);

// File: tb/test_pwm_seq_decoder.sv
`timescale 1ns/1ps
module test_pwm_seq_decoder;
   localparam int PER = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] base_addr_i = '0;
   logic [15:0] len_i = '0;
   logic [2:0]  cfg_i = '0;
   logic [7:0]  refresh_i = '0;
   logic        period_end_i = 1'b0;
   logic        next_step_i = 1'b0;
   logic        req_valid_o;
   logic [31:0] req_addr_o;
   logic        req_ready_i = 1'b0;
   logic        rsp_valid_i = 1'b0;
   logic [15:0] rsp_data_i = '0;
   logic [63:0] cmp_o;
   logic [15:0] top_o;
   logic        last_read_o, done_o, busy_o;

   pwm_seq_decoder i_pwm_seq_decoder (.*);

   always #10 clk = ~clk;

   int vectors = 0, fails = 0;
   int hs_count, rcount, last_cnt;
   int cur_len;
   logic [31:0] cur_base;
   logic [15:0] exp_ch [4];
   logic [15:0] exp_top;

   function automatic logic [15:0] mem_val(logic [31:0] a);
      logic [31:0] h;
      h = a * 32'h9E37 ^ (a >> 5) ^ 32'h5A5A;
      return h[15:0];
   endfunction

   function automatic int hwps(int m);
      return (m == 0) ? 1 : (m == 1) ? 2 : 4;
   endfunction

   function automatic logic [63:0] exp_pack();
      return {exp_ch[3], exp_ch[2], exp_ch[1], exp_ch[0]};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected outputs after step j is applied (R3..R6)
   task automatic apply_exp(input int mode, input int j);
      int k;
      logic [15:0] h [4];
      k = hwps(mode);
      for (int i = 0; i < 4; i++) h[i] = (i < k) ? mem_val(cur_base + 32'(2 * (j * k + i))) : 16'h0;
      case (mode)
         0: for (int c = 0; c < 4; c++) exp_ch[c] = h[0];
         1: for (int c = 0; c < 4; c++) exp_ch[c] = h[c / 2];
         2: for (int c = 0; c < 4; c++) exp_ch[c] = h[c];
         default: begin
            for (int c = 0; c < 3; c++) exp_ch[c] = h[c];
            exp_top = h[3];
         end
      endcase
   endtask

   // memory responder and last-read monitor
   initial begin
      bit pend = 0, hs_next = 0, prev_low = 0;
      int dly = 0;
      logic [31:0] paddr = '0, haddr = '0;
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            if (hs_next) begin
               pend = 1; paddr = haddr; dly = $urandom % 3;
            end
            rsp_valid_i = 1'b0;
            if (pend) begin
               if (dly == 0) begin
                  rsp_valid_i = 1'b1; rsp_data_i = mem_val(paddr); pend = 0; rcount++;
               end else dly--;
            end
            req_ready_i = prev_low ? 1'b1 : (($urandom % 4) != 0);
            prev_low = !req_ready_i;
            hs_next = req_valid_o && req_ready_i;
            if (hs_next) begin
               chk(req_addr_o == cur_base + 32'(2 * hs_count), "R2 address order",
                   64'(req_addr_o), 64'(cur_base + 32'(2 * hs_count)));
               haddr = req_addr_o;
               hs_count++;
            end
            if (last_read_o) begin
               last_cnt++;
               chk(rcount == cur_len, "R10 last-read after final halfword", 64'(rcount), 64'(cur_len));
            end
         end
      end
   end

   task automatic pulse_period(input string tag);
      repeat (PER) @(posedge clk);
      #1;
      chk({top_o, cmp_o} == {exp_top, exp_pack()}, "R7 stable between boundaries",
          64'(cmp_o), exp_pack());
      period_end_i = 1'b1;
      @(posedge clk); #1;
      period_end_i = 1'b0;
   endtask

   task automatic pulse_step();
      @(posedge clk); #1 next_step_i = 1'b1;
      @(posedge clk); #1 next_step_i = 1'b0;
   endtask

   task automatic check_outs(input string tag);
      chk(cmp_o == exp_pack(), tag, cmp_o, exp_pack());
      chk(top_o == exp_top, tag, 64'(top_o), 64'(exp_top));
   endtask

   task automatic run_seq(input int mode, input bit trig, input int refresh, input int nsteps, input logic [31:0] base);
      string mtag;
      mtag = (mode == 0) ? "R3 common" : (mode == 1) ? "R4 paired" : (mode == 2) ? "R5 split" : "R6 wave";
      cur_base = base; cur_len = nsteps * hwps(mode);
      hs_count = 0; rcount = 0; last_cnt = 0;
      @(posedge clk); #1;
      base_addr_i = base; len_i = 16'(cur_len); cfg_i = {trig, 2'(mode)}; refresh_i = 8'(refresh);
      start_i = 1'b1;
      @(posedge clk); #1 start_i = 1'b0;
      for (int j = 0; j < nsteps; j++) begin
         if (trig && j > 0) begin
            pulse_period("R9");
            check_outs("R9 no advance without step pulse");
            pulse_step();
         end
         pulse_period(mtag);
         apply_exp(mode, j);
         check_outs(trig ? "R9 step after pulse" : mtag);
         check_outs(mtag);
         chk(busy_o == 1'b1, "R8 busy while playing", 64'(busy_o), 64'd1);
         if (!trig) for (int r = 0; r < refresh; r++) begin
            pulse_period("R8");
            check_outs("R8 step held for refresh periods");
         end
      end
      if (trig) pulse_step();
      pulse_period("R11");
      chk(done_o == 1'b1 && busy_o == 1'b0, "R11 done and idle", {62'd0, done_o, busy_o}, 64'd2);
      check_outs("R11 outputs kept");
      @(posedge clk); #1;
      chk(done_o == 1'b0, "R11 done one cycle", 64'(done_o), 64'd0);
      chk(last_cnt == 1, "R10 single last-read", 64'(last_cnt), 64'd1);
      chk(hs_count == cur_len, "R2 request count", 64'(hs_count), 64'(cur_len));
   endtask

   initial begin
      void'($urandom(32'd2718));
      exp_ch = '{default: 16'h0};
      exp_top = 16'h03FF;
      cur_base = '0; cur_len = 0; hs_count = 0; rcount = 0; last_cnt = 0;
      repeat (3) @(posedge clk);
      #1;
      chk(cmp_o == 64'd0 && top_o == 16'h03FF, "R1 reset outputs", {top_o, cmp_o[47:0]}, {16'h03FF, 48'd0});
      chk({busy_o, done_o, last_read_o, req_valid_o} == 4'b0, "R1 reset flags",
          64'({busy_o, done_o, last_read_o, req_valid_o}), 64'd0);
      rst_n = 1'b1;
      // directed corner cases (R12 encodings)
      run_seq(0, 1'b0, 0, 3, 32'h0000_1000);
      run_seq(1, 1'b0, 2, 2, 32'h0000_2002);
      run_seq(2, 1'b0, 1, 2, 32'h0000_3000);
      run_seq(3, 1'b0, 0, 3, 32'h0000_4010);
      run_seq(2, 1'b1, 3, 3, 32'h0000_5000);
      run_seq(3, 1'b1, 5, 1, 32'h0000_6000);
      run_seq(0, 1'b0, 0, 1, 32'h0000_7FFE);
      // constrained random
      for (int n = 0; n < 10; n++) begin
         run_seq($urandom % 4, 1'($urandom % 2), $urandom % 4, 1 + $urandom % 4,
                 {16'h0, 16'($urandom)} & 32'hFFFF_FFFE);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule